// File: doc/BRIEF.md
# E-clock synchronous peripheral cycle sequencer

This block lets an asynchronous bus master reach slow synchronous peripherals, which never return a transfer acknowledge. It divides the CPU clock into a free-running enable clock E, low for `E_LOW` clocks and then high for `E_HIGH` clocks. E keeps running whether or not the bus is busy, so its phase against any access is arbitrary.

An access whose upper address bit is set is decoded as a synchronous-peripheral access, and the valid-peripheral flag `vpa_o` is raised. The sequencer then waits for the next E high-to-low edge, which opens the peripheral's E cycle. It holds the master in wait states for that whole E period. It drives the peripheral enable during the E high phase, strobes read data as E falls at the end of the period, and then pulses a one-clock done. After done, it does not start a second access until the strobe has been released.

Top module: `e_sync_seq`

## Requirements
- R1: From reset E counts from zero: `e_o` is low for the first `E_LOW` (6) clocks, high for the next `E_HIGH` (4), and repeats with period 10 regardless of bus activity.
- R2: `vpa_o` goes high one clock after `as_i` is sampled high with `addr_hi_i` high, and is never high for an access with `addr_hi_i` low.
- R3: `vpa_o` goes low one clock after `as_i` is sampled low.
- R4: The peripheral E cycle starts at the first E falling edge that the sequencer sees while it is waiting, with E sampled high just before that edge. With the strobe driven after posedge k0, that edge is the first posedge m ≥ k0+3 at which the E count wraps (m a multiple of 10).
- R5: `per_en_o` is high for exactly the 4 high-phase clocks of the selected E cycle (after posedges m+6 to m+9) and low at all other times.
- R6: For a read (`rd_i`=1), `rd_latch_o` is high for the single clock that ends with the E falling edge closing the cycle (after posedge m+9). For a write it stays low.
- R7: `done_o` is a one-clock pulse in the clock after the closing E falling edge (after posedge m+10).
- R8: If the strobe is released early enough that `vpa_o` is already low at the edge that would open the E cycle (release after posedge m-2 or earlier), the access is abandoned with no enable, latch or done. A release after posedge m-1 or later lets the cycle complete.
- R9: While the strobe stays asserted after done, no further E cycle is started.
- R10: During reset, `e_o`, `vpa_o`, `per_en_o`, `rd_latch_o` and `done_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| as_i | input | 1 | Address strobe from the bus master, active high |
| addr_hi_i | input | 1 | Upper address bit; 1 selects the synchronous region |
| rd_i | input | 1 | Transfer direction, 1 = read, 0 = write |
| e_o | output | 1 | Free-running E clock |
| vpa_o | output | 1 | Valid peripheral address, registered decode |
| per_en_o | output | 1 | Peripheral enable during the selected E high phase |
| rd_latch_o | output | 1 | Read data capture strobe on the closing E fall |
| done_o | output | 1 | One-clock end-of-cycle pulse |

## Verification
The hardest situations to reach from the ports are the edge of the abandon window and a wait that begins exactly as E falls. In the first, the strobe drops one clock before or after the last moment that still lets the cycle open. In the second, the sequencer has to wait a whole extra E period. The bench steps the strobe's launch through all ten E phases, so every wait length from 3 to 12 clocks occurs. It also times releases against the predicted opening edge, at m-2, at m-1 and inside the cycle, and compares every output on every clock with a schedule worked out from m.

// File: rtl/e_sync_pkg.sv
package e_sync_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_HI,
    ST_WAIT_FALL,
    ST_CYCLE,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/e_clk_gen.sv
module e_clk_gen #(
  parameter int E_LOW  = 6,
  parameter int E_HIGH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic e_o,
  output logic e_last_o
);
  localparam int PERIOD = E_LOW + E_HIGH;
  localparam int CW     = $clog2(PERIOD + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (cnt_q == CW'(PERIOD - 1))   cnt_q <= '0;
    else                                 cnt_q <= cnt_q + 1'b1;
  end

  assign e_o      = (cnt_q >= CW'(E_LOW));
  assign e_last_o = (cnt_q == CW'(PERIOD - 1));

  assert_cnt_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(PERIOD));
  assert_fall_at_wrap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(e_o) |-> (cnt_q == '0));
endmodule

// File: rtl/vpa_decode.sv
module vpa_decode (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic as_i,
  input  logic addr_hi_i,
  output logic vpa_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vpa_o <= 1'b0;
    else         vpa_o <= as_i & addr_hi_i;
  end

  assert_vpa_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !as_i |=> !vpa_o);
  assert_vpa_region_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_hi_i |=> !vpa_o);
endmodule

// File: rtl/e_cycle_fsm.sv
module e_cycle_fsm
  import e_sync_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vpa_i,
  input  logic e_i,
  input  logic e_last_i,
  input  logic rd_i,
  output logic per_en_o,
  output logic rd_latch_o,
  output logic done_o
);
  seq_state_e state_q, state_d;
  logic       held_q;
  logic       in_cyc;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (vpa_i && !held_q) state_d = ST_WAIT_HI;
      ST_WAIT_HI: begin
        if (!vpa_i)        state_d = ST_IDLE;
        else if (e_last_i) state_d = ST_CYCLE;
        else if (e_i)      state_d = ST_WAIT_FALL;
      end
      ST_WAIT_FALL: begin
        if (!vpa_i)        state_d = ST_IDLE;
        else if (e_last_i) state_d = ST_CYCLE;
      end
      ST_CYCLE:     if (e_last_i) state_d = ST_DONE;
      ST_DONE:      state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      held_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_DONE) held_q <= 1'b1;
      else if (!vpa_i)        held_q <= 1'b0;
    end
  end

  assign in_cyc     = (state_q == ST_CYCLE);
  assign per_en_o   = in_cyc && e_i;
  assign rd_latch_o = in_cyc && e_last_i && rd_i;
  assign done_o     = (state_q == ST_DONE);

  assert_start_on_e_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_cyc) |-> $fell(e_i));
  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_after_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(in_cyc) && $fell(e_i)));
  assert_latch_then_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_latch_o |=> done_o);
  assert_no_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_q && vpa_i) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/e_sync_seq.sv
module e_sync_seq #(
  parameter int E_LOW  = 6,
  parameter int E_HIGH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic as_i,
  input  logic addr_hi_i,
  input  logic rd_i,
  output logic e_o,
  output logic vpa_o,
  output logic per_en_o,
  output logic rd_latch_o,
  output logic done_o
);
  logic e_last;

  e_clk_gen #(.E_LOW(E_LOW), .E_HIGH(E_HIGH)) u_egen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .e_o      (e_o),
    .e_last_o (e_last)
  );

  vpa_decode u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .as_i      (as_i),
    .addr_hi_i (addr_hi_i),
    .vpa_o     (vpa_o)
  );

  e_cycle_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vpa_i      (vpa_o),
    .e_i        (e_o),
    .e_last_i   (e_last),
    .rd_i       (rd_i),
    .per_en_o   (per_en_o),
    .rd_latch_o (rd_latch_o),
    .done_o     (done_o)
  );
endmodule

// File: tb/e_sync_seq_test.sv
`timescale 1ns/1ps
module e_sync_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic as_r = 1'b0, hi_r = 1'b0, rd_r = 1'b0;
  logic e, vpa, pen, rdl, done;
  int   k;
  int   checks = 0, fails = 0;
  bit   finished = 1'b0;

  always #2.5 clk = ~clk;

  e_sync_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .as_i(as_r), .addr_hi_i(hi_r), .rd_i(rd_r),
    .e_o(e), .vpa_o(vpa), .per_en_o(pen), .rd_latch_o(rdl), .done_o(done)
  );

  // posedges since reset release
  always @(posedge clk or negedge rst_n)
    if (!rst_n) k <= 0;
    else        k <= k + 1;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s k=%0d: actual %0d expected %0d", req, what, k, act, exp);
    end
  endtask

  task automatic run(int ph, bit hi, bit rw, bit from_m, int ofs, string tag);
    int k0, m, r, end_k;
    bit cyc;
    do @(negedge clk); while ((k % 10) != ph);
    k0 = k;
    as_r = 1'b1; hi_r = hi; rd_r = rw;
    m   = ((k0 + 3 + 9) / 10) * 10;
    r   = from_m ? m + ofs : k0 + ofs;
    cyc = hi && (r >= m - 1);
    end_k = ((r > m + 10) ? r : m + 10) + 3;
    while (k < end_k) begin
      @(negedge clk);
      chk("R1", "e", int'(e), int'((k % 10) >= 6));
      chk((k <= r) ? "R2" : "R3", "vpa", int'(vpa),
          int'(hi && k >= k0 + 1 && k <= r));
      chk("R4 R5", tag, int'(pen), int'(cyc && k >= m + 6 && k <= m + 9));
      chk("R6", tag, int'(rdl), int'(cyc && rw && k == m + 9));
      chk("R7", tag, int'(done), int'(cyc && k == m + 10));
      if (k == r) as_r = 1'b0;
    end
    as_r = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", "e", int'(e), 0);
    chk("R10", "vpa", int'(vpa), 0);
    chk("R10", "pen", int'(pen), 0);
    chk("R10", "rd_latch", int'(rdl), 0);
    chk("R10", "done", int'(done), 0);
    rst_n = 1'b1;
    // every launch phase, both regions, strobe held long after done
    for (int ph = 0; ph < 10; ph++)
      for (int hi = 0; hi < 2; hi++)
        run(ph, 1'(hi), 1'(ph % 2), 1'b1, 30, "R9");
    // early release abandons the access
    run(0, 1'b1, 1'b1, 1'b0, 1, "R8");
    run(5, 1'b1, 1'b1, 1'b0, 1, "R8");
    run(9, 1'b1, 1'b0, 1'b0, 2, "R8");
    // release boundary around the opening edge
    for (int ph = 0; ph < 10; ph += 3) begin
      run(ph, 1'b1, 1'b1, 1'b1, -2, "R8 abort");
      run(ph, 1'b1, 1'b1, 1'b1, -1, "R8 proceed");
    end
    // release inside the E cycle
    run(4, 1'b1, 1'b1, 1'b1, 3, "R8 midcycle");
    run(7, 1'b1, 1'b0, 1'b1, 9, "R8 late");
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule